// File: doc/BRIEF.md
# Serial Receiver with Wide Status Packing

This block turns an asynchronous serial line into bytes for a receive FIFO. It oversamples the line with a tick input running at sixteen times the bit rate. A falling edge is confirmed as a start bit by a sample half a bit later. The block then collects 5 to 9 data bits, least significant bit first, plus an optional parity bit and one stop bit. From these it derives parity error, framing error and break. When the downstream FIFO has no room, the character is dropped and an overrun is recorded.

Software chooses between two packing modes. In compact mode every stored character costs exactly one FIFO byte: the data, zero-extended above the character width and cut to 8 bits, with all status discarded. In wide mode every stored character costs two FIFO bytes on consecutive cycles. The first byte is the data and the second is a status byte that also carries the ninth data bit. The word size, parity enable, parity sense and mode are captured when a start bit is confirmed, so a configuration change never splits a character.

Top module: `rx_char_packer`

## Requirements
- R1: After reset `push_valid` is 0 and stays 0 while the line idles high. A status byte is only ever pushed in the cycle right after its data byte.
- R2: In compact mode (`cfg_wide`=0) a character of 5 to 8 bits produces exactly one push of its data byte, with bits above the character width at 0. Parity, framing, overrun and break results are discarded.
- R3: In compact mode a 9-bit character (`cfg_data_bits`=9) produces one push holding data bits 7..0. Bit 8 and all status are discarded.
- R4: In wide mode (`cfg_wide`=1) each stored character produces two pushes on consecutive clock cycles: the data byte first, then the status byte.
- R5: The status byte has this layout: bit 0 parity error, bit 1 framing error, bit 2 overrun, bit 3 break, bit 4 data bit 8 (9-bit words only, else 0). Bits 7..5 are 0.
- R6: With parity enabled and a word of 5 to 8 bits, a parity bit follows the data. Even parity (`cfg_parity_odd`=0) expects an even count of ones over data plus parity bit. Odd parity expects an odd count. A mismatch sets the parity error flag.
- R7: With 9-bit words no parity bit is received, even if parity is enabled, and the parity error flag stays 0.
- R8: A stop bit sampled as 0 sets the framing error flag.
- R9: Break is flagged when all data bits, the parity bit (if present) and the stop bit are 0. After a 0 stop bit, a new start bit is not searched for until the line has returned high.
- R10: A character that finds no room is not pushed at all. The next stored character carries overrun (status bit 2), and the overrun record is cleared by any stored character, in either mode.
- R11: Room means `fifo_free` of at least 1 in compact mode and at least 2 in wide mode. A wide-mode character with only one free byte is dropped.
- R12: A low pulse shorter than half a bit time, so that the line is high again at the mid-start sample, produces no push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, OS_RATE pulses per bit time |
| rx_line | input | 1 | Serial receive line, idle high |
| cfg_data_bits | input | 4 | Word length 5..9; smaller values act as 5, larger as 9 |
| cfg_parity_en | input | 1 | Parity bit present (ignored for 9-bit words) |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_wide | input | 1 | 1 = push data and status bytes, 0 = data byte only |
| fifo_free | input | FREE_W | Free byte count of the downstream FIFO |
| push_valid | output | 1 | FIFO write strobe |
| push_data | output | 8 | FIFO write byte |

## Verification
The hardest state to reach from the ports is the overrun flag. It needs a character to be lost and a later one to be stored, and its record must survive a mode change and be cleared by a compact-mode character. The stimulus holds `fifo_free` at 0 or 1 during one character, then raises it and sends further characters in wide mode to read the flag and confirm that it clears. Break and framing cases are produced by driving a low stop bit. The bench checks that the trailing low half stop bit causes no extra character.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAITHI
  } rx_state_t;

  // One received character plus the configuration captured for it.
  typedef struct packed {
    logic [8:0] data;
    logic       par_bit;
    logic       stop_bit;
    logic [3:0] nbits;
    logic       par_en;
    logic       par_odd;
    logic       wide;
  } rx_frame_t;

  localparam logic [3:0] MIN_BITS = 4'd5;
  localparam logic [3:0] MAX_BITS = 4'd9;

  function automatic logic [3:0] clamp_bits(input logic [3:0] b);
    if (b < MIN_BITS) return MIN_BITS;
    if (b > MAX_BITS) return MAX_BITS;
    return b;
  endfunction

  function automatic logic [8:0] width_mask(input logic [3:0] nb);
    logic [9:0] t;
    t = (10'd1 << nb) - 10'd1;
    return t[8:0];
  endfunction

  function automatic logic parity_present(input rx_frame_t f);
    return f.par_en && (f.nbits != MAX_BITS);
  endfunction

  function automatic logic parity_bad(input rx_frame_t f);
    logic ones;
    ones = ^(f.data & width_mask(f.nbits));
    return parity_present(f) && (ones ^ f.par_bit ^ f.par_odd);
  endfunction

  function automatic logic line_break(input rx_frame_t f);
    logic par_low;
    par_low = !parity_present(f) || !f.par_bit;
    return ((f.data & width_mask(f.nbits)) == 9'd0) && par_low && !f.stop_bit;
  endfunction

  function automatic logic [7:0] pack_status(input logic perr, input logic ferr,
                                             input logic ovr, input logic brk,
                                             input logic b8);
    return {3'b000, b8, brk, ovr, ferr, perr};
  endfunction

endpackage

// File: rtl/srx_frame_engine.sv
module srx_frame_engine
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_line,
  input  logic [3:0] cfg_data_bits,
  input  logic       cfg_parity_en,
  input  logic       cfg_parity_odd,
  input  logic       cfg_wide,
  output logic       frame_done,
  output rx_frame_t  frame
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_t              state;
  logic [CNT_W-1:0]       cnt;
  logic [3:0]             bit_idx;
  logic                   at_mid;
  logic                   at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
  end
  assign rx_s    = sync_q[SYNC_STAGES-1];
  assign at_mid  = (cnt == MID_CNT);
  assign at_last = (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      frame      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (state == S_WAITHI) begin
        if (rx_s) state <= S_IDLE;
      end else if (os_tick) begin
        case (state)
          S_IDLE: begin
            cnt <= '0;
            if (!rx_s) state <= S_START;
          end
          S_START: begin
            if (at_mid) begin
              cnt <= '0;
              if (!rx_s) begin
                state          <= S_DATA;
                bit_idx        <= '0;
                frame.data     <= '0;
                frame.par_bit  <= 1'b0;
                frame.nbits    <= clamp_bits(cfg_data_bits);
                frame.par_en   <= cfg_parity_en;
                frame.par_odd  <= cfg_parity_odd;
                frame.wide     <= cfg_wide;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (at_last) begin
              cnt                 <= '0;
              frame.data[bit_idx] <= rx_s;
              if (bit_idx == frame.nbits - 4'd1)
                state <= parity_present(frame) ? S_PAR : S_STOP;
              else
                bit_idx <= bit_idx + 4'd1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (at_last) begin
              cnt           <= '0;
              frame.par_bit <= rx_s;
              state         <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (at_last) begin
              cnt            <= '0;
              frame.stop_bit <= rx_s;
              frame_done     <= 1'b1;
              state          <= rx_s ? S_IDLE : S_WAITHI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srx_status_eval.sv
module srx_status_eval
  import serial_rx_pkg::*;
(
  input  rx_frame_t   frame,
  output logic [7:0]  data_byte,
  output logic        perr,
  output logic        ferr,
  output logic        brk,
  output logic        bit8
);
  logic [8:0] masked;

  always_comb begin
    masked    = frame.data & width_mask(frame.nbits);
    data_byte = masked[7:0];
    perr      = parity_bad(frame);
    ferr      = !frame.stop_bit;
    brk       = line_break(frame);
    bit8      = (frame.nbits == MAX_BITS) ? masked[8] : 1'b0;
  end
endmodule

// File: rtl/srx_push_ctrl.sv
module srx_push_ctrl
  import serial_rx_pkg::*;
#(
  parameter int FREE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              wide,
  input  logic [7:0]        data_byte,
  input  logic              perr,
  input  logic              ferr,
  input  logic              brk,
  input  logic              bit8,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              push_valid,
  output logic [7:0]        push_data,
  output logic              status_phase,
  output logic              room_ok
);
  logic [FREE_W-1:0] need;
  logic              ovr_pend;
  logic              stat_pend;
  logic [7:0]        stat_hold;

  assign need    = wide ? FREE_W'(2) : FREE_W'(1);
  assign room_ok = (fifo_free >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_valid   <= 1'b0;
      push_data    <= '0;
      status_phase <= 1'b0;
      ovr_pend     <= 1'b0;
      stat_pend    <= 1'b0;
      stat_hold    <= '0;
    end else begin
      push_valid   <= 1'b0;
      status_phase <= 1'b0;
      if (stat_pend) begin
        push_valid   <= 1'b1;
        push_data    <= stat_hold;
        status_phase <= 1'b1;
        stat_pend    <= 1'b0;
      end else if (frame_done) begin
        if (room_ok) begin
          push_valid <= 1'b1;
          push_data  <= data_byte;
          ovr_pend   <= 1'b0;
          if (wide) begin
            stat_pend <= 1'b1;
            stat_hold <= pack_status(perr, ferr, ovr_pend, brk, bit8);
          end
        end else begin
          ovr_pend <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_char_packer.sv
module rx_char_packer
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int FREE_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic [3:0]        cfg_data_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_wide,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              push_valid,
  output logic [7:0]        push_data
);
  logic       frame_done;
  rx_frame_t  frame;
  logic [7:0] data_byte;
  logic       perr;
  logic       ferr;
  logic       brk;
  logic       bit8;
  logic       status_phase;
  logic       room_ok;
  logic       cur_wide;

  assign cur_wide = frame.wide;

  srx_frame_engine #(.OS_RATE(OS_RATE), .SYNC_STAGES(2)) u_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .os_tick        (os_tick),
    .rx_line        (rx_line),
    .cfg_data_bits  (cfg_data_bits),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_wide       (cfg_wide),
    .frame_done     (frame_done),
    .frame          (frame)
  );

  srx_status_eval u_eval (
    .frame     (frame),
    .data_byte (data_byte),
    .perr      (perr),
    .ferr      (ferr),
    .brk       (brk),
    .bit8      (bit8)
  );

  srx_push_ctrl #(.FREE_W(FREE_W)) u_push (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done   (frame_done),
    .wide         (cur_wide),
    .data_byte    (data_byte),
    .perr         (perr),
    .ferr         (ferr),
    .brk          (brk),
    .bit8         (bit8),
    .fifo_free    (fifo_free),
    .push_valid   (push_valid),
    .push_data    (push_data),
    .status_phase (status_phase),
    .room_ok      (room_ok)
  );
endmodule

// File: rtl/rx_char_packer_chk.sv
module rx_char_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       push_valid,
  input logic [7:0] push_data,
  input logic       status_phase,
  input logic       frame_done,
  input logic       room_ok,
  input logic       cur_wide
);
  a_r1_status_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && status_phase) |-> $past(push_valid && !status_phase));

  a_r2_single_push_compact: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !cur_wide) |=> !push_valid);

  a_r4_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !status_phase && cur_wide) |=> (push_valid && status_phase));

  a_r5_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && status_phase) |-> (push_data[7:5] == 3'b000));

  a_r7_nine_bit_no_perr: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && status_phase && push_data[4]) |-> !push_data[0]);

  a_r9_break_has_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && status_phase && push_data[3]) |-> push_data[1]);

  a_r10_drop_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !room_ok) |=> !push_valid);
endmodule

bind rx_char_packer rx_char_packer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .push_valid   (push_valid),
  .push_data    (push_data),
  .status_phase (status_phase),
  .frame_done   (frame_done),
  .room_ok      (room_ok),
  .cur_wide     (cur_wide)
);

// File: tb/tb_rx_char_packer.sv
`timescale 1ns/1ps
module tb_rx_char_packer;
  localparam int FREE_W  = 10;
  localparam int BIT_CLK = 32; // 16 ticks per bit, one tick every 2 clocks
  localparam int NVEC    = 13;

  // {nbits[3:0], par_en, par_odd, wide, flip_parity, stop, value[8:0]}
  localparam logic [17:0] VECS [0:NVEC-1] = '{
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0A5},  // R2 compact 8 bit
    {4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0FF},  // R2 zero upper bit
    {4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 9'h013},  // R2 parity error discarded
    {4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h1C3},  // R3 compact 9 bit
    {4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 9'h03C},  // R4 R6 good even
    {4'd8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 9'h03C},  // R6 bad even
    {4'd6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h02A},  // R6 bad odd
    {4'd7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 9'h055},  // R6 good odd
    {4'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 9'h1A5},  // R7 R5 bit 8
    {4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h05A},  // R8 framing
    {4'd8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000},  // R9 break
    {4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h000},  // R9 zero data, not break
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000}   // R2 break discarded
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              os_tick = 1'b0;
  logic              rx_line = 1'b1;
  logic [3:0]        cfg_data_bits = 4'd8;
  logic              cfg_parity_en = 1'b0;
  logic              cfg_parity_odd = 1'b0;
  logic              cfg_wide = 1'b0;
  logic [FREE_W-1:0] fifo_free = FREE_W'(100);
  logic              push_valid;
  logic [7:0]        push_data;

  int checks = 0;
  int fails  = 0;
  int ngot   = 0;
  int cyc    = 0;
  logic [7:0] got_data [0:63];
  int         got_cyc  [0:63];

  rx_char_packer #(.OS_RATE(16), .FREE_W(FREE_W)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .os_tick        (os_tick),
    .rx_line        (rx_line),
    .cfg_data_bits  (cfg_data_bits),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_wide       (cfg_wide),
    .fifo_free      (fifo_free),
    .push_valid     (push_valid),
    .push_data      (push_data)
  );

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    os_tick = ~os_tick;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && push_valid && ngot < 64) begin
      got_data[ngot] = push_data;
      got_cyc[ngot]  = cyc;
      ngot = ngot + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bit_time(input logic v);
    rx_line = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(input int nb, input logic pen, input logic podd,
                            input logic flip, input logic stop, input logic [8:0] val);
    int ones;
    ones = 0;
    bit_time(1'b0);
    for (int i = 0; i < nb; i++) begin
      bit_time(val[i]);
      if (val[i]) ones = ones + 1;
    end
    if (pen && nb != 9) bit_time(((ones % 2) == 1) ^ podd ^ flip);
    bit_time(stop);
    rx_line = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
  endtask

  // Sends one character and compares the pushes with a model of the requirements.
  task automatic run_char(input string req, input int nb, input logic pen, input logic podd,
                          input logic wide, input logic flip, input logic stop,
                          input logic [8:0] val, input logic exp_ovr);
    int base;
    int masked;
    int st;
    logic pbit_zero;
    int ones;
    cfg_data_bits  = 4'(nb);
    cfg_parity_en  = pen;
    cfg_parity_odd = podd;
    cfg_wide       = wide;
    base = ngot;
    send_frame(nb, pen, podd, flip, stop, val);
    masked = int'(val) % (1 << nb);
    ones = 0;
    for (int i = 0; i < nb; i++) if (((masked >> i) & 1) == 1) ones = ones + 1;
    pbit_zero = !(pen && nb != 9) || ((((ones % 2) == 1) ^ podd ^ flip) == 1'b0);
    st = 0;
    if (pen && nb != 9 && flip) st = st + 1;
    if (!stop) st = st + 2;
    if (exp_ovr) st = st + 4;
    if (masked == 0 && pbit_zero && !stop) st = st + 8;
    if (nb == 9 && val[8]) st = st + 16;
    chk({req, " push count"}, ngot - base, wide ? 2 : 1);
    if (ngot - base >= 1) chk({req, " data byte"}, got_data[base], masked % 256);
    if (wide && ngot - base >= 2) begin
      chk({req, " status byte"}, got_data[base + 1], st);
      chk({req, " R4 adjacent pushes"}, got_cyc[base + 1] - got_cyc[base], 1);
    end
  endtask

  task automatic expect_drop(input string req, input int nb, input logic wide,
                             input logic [8:0] val);
    int base;
    cfg_data_bits  = 4'(nb);
    cfg_parity_en  = 1'b0;
    cfg_wide       = wide;
    base = ngot;
    send_frame(nb, 1'b0, 1'b0, 1'b0, 1'b1, val);
    chk({req, " dropped, no push"}, ngot - base, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    chk("R1 reset push_valid", int'(push_valid), 0);
    rst_n = 1'b1;
    repeat (4 * BIT_CLK) @(negedge clk);
    chk("R1 idle no push", ngot, 0);

    for (int k = 0; k < NVEC; k++) begin
      logic [17:0] v;
      v = VECS[k];
      run_char($sformatf("vec%0d R2/R3/R4/R5/R6/R7/R8/R9", k), int'(v[17:14]), v[13], v[12],
               v[11], v[10], v[9], v[8:0], 1'b0);
    end

    // R12: short low glitch
    base = ngot;
    rx_line = 1'b0;
    repeat (8) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    chk("R12 glitch no push", ngot - base, 0);

    // R9: long break, line held low well past the stop bit, one character only
    cfg_data_bits = 4'd8; cfg_parity_en = 1'b0; cfg_wide = 1'b1;
    base = ngot;
    rx_line = 1'b0;
    repeat (14 * BIT_CLK) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    chk("R9 long break pushes", ngot - base, 2);
    if (ngot - base == 2) chk("R9 long break status", got_data[base + 1], 8'h0A);

    // R10: loss in compact mode, flag seen on next wide character, then cleared
    fifo_free = FREE_W'(0);
    expect_drop("R10 no room compact", 8, 1'b0, 9'h011);
    fifo_free = FREE_W'(100);
    run_char("R10 overrun reported", 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h022, 1'b1);
    run_char("R10 overrun cleared", 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h033, 1'b0);

    // R11: wide needs two bytes; compact fits in one and clears the record
    fifo_free = FREE_W'(1);
    expect_drop("R11 one byte wide", 8, 1'b1, 9'h044);
    run_char("R11 one byte compact", 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h055, 1'b0);
    fifo_free = FREE_W'(2);
    run_char("R11 R10 cleared by compact", 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h066, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule